// File: doc/BRIEF.md
# Adaptive LSB Prebackup Policy Selector

This block sits in the write path of a multi-level-cell flash controller. Each host write request arrives with three values:

- its length in pages;
- how many pages the channel and way fabric can program at once;
- how many of those program slots are currently idle.

It also arrives with one bit per page position. That bit tells whether the page lands on a lower page whose paired upper page lies outside this request.

From these inputs the block decides how the exposed lower pages are protected. There are four outcomes:

- no backup at all;
- mirrored writes on spare slots, issued alongside the data;
- an on-die copy from the page buffer, issued right after the data;
- an XOR page that covers two lower pages with one backup write.

The block reports which pages need a backup and how many backup pages the chosen method will write. A lower page whose upper partner belongs to the same request is never protected. If the request is cut short, the whole request is discarded anyway. Only the tail of the request, up to the pairing distance, can hold exposed pages.

The decision is registered and appears one cycle after the request strobe. It then holds until the next request. Command scheduling downstream consumes the decision; it is not part of this block.

Top module: `lsb_backup_selector`

## Requirements
- R1: While reset is high and on the first cycle after it, `dec_valid` is 0, `dec_mode` is 0 (none), `bkp_flags` is all zero and `bkp_count` is 0.
- R2: `dec_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, and 0 otherwise.
- R3: A request with `req_len` = 0 yields `dec_mode` = 0 (none), all-zero `bkp_flags` and `bkp_count` = 0.
- R4: For a request with 0 < `req_len`, twice the length not above `par_pages`, and `idle_slots` at least twice the length, `dec_mode` is 1 (mirrored on idle slots).
- R5: For a nonzero request not meeting R4 and with `req_len` ≤ `par_pages`, `dec_mode` is 2 (page-buffer copy). This includes a small request that lacks idle slots.
- R6: For a request with `req_len` > `par_pages`, `dec_mode` is 3 (XOR parity).
- R7: Bit i of `bkp_flags` (bit 0 is the first page of the request) is 1 only when all three hold: i < `req_len`, i + `PAIR_GAP` ≥ `req_len`, and bit i of `lsb_ext` is 1. Bits of `lsb_ext` outside that window have no effect.
- R8: `bkp_count` equals the number of set `bkp_flags` bits in modes 0, 1 and 2. In mode 3 it equals that number halved, rounded up.
- R9: While `req_valid` is low, `dec_mode`, `bkp_flags` and `bkp_count` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_len | input | LEN_W | Request length in pages |
| par_pages | input | PAR_W | Pages programmable concurrently |
| idle_slots | input | SLOT_W | Currently idle program slots |
| lsb_ext | input | MAX_PAGES | Per page: lower page with its partner outside the request |
| dec_valid | output | 1 | Decision valid strobe |
| dec_mode | output | 2 | 0 none, 1 mirrored, 2 buffer copy, 3 parity |
| bkp_flags | output | MAX_PAGES | Per page backup required |
| bkp_count | output | CNT_W | Backup pages to be written |

## Verification
The assertions take for granted that `req_len` never exceeds `MAX_PAGES`, so every page of a request has a flag position. The stimulus sweeps lengths only from 0 to `MAX_PAGES`. The sweep covers every slot-capacity value the port width allows. The idle-slot value is set just below, exactly at, and far above twice the length, so the mode thresholds are hit on both sides. Between requests, the length and page-flag inputs are inverted while the strobe is low, to show that the held decision ignores them.

// File: rtl/lsbsel_pkg.sv
package lsbsel_pkg;
  typedef enum logic [1:0] {
    BK_NONE   = 2'd0,
    BK_MIRROR = 2'd1,
    BK_COPY   = 2'd2,
    BK_PARITY = 2'd3
  } bk_mode_e;
endpackage

// File: rtl/lsbsel_mode.sv
module lsbsel_mode
  import lsbsel_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int PAR_W  = 4,
  parameter int SLOT_W = 5
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [PAR_W-1:0]  par,
  input  logic [SLOT_W-1:0] idle,
  output bk_mode_e          mode
);
  localparam int MW = (LEN_W > PAR_W) ? LEN_W : PAR_W;
  localparam int CW = ((MW > SLOT_W) ? MW : SLOT_W) + 2;

  logic [CW-1:0] len_x, par_x, idle_x, dbl_x;
  logic          fits_half, fits_full, slots_ok;

  always_comb begin
    len_x     = CW'(len);
    par_x     = CW'(par);
    idle_x    = CW'(idle);
    dbl_x     = len_x << 1;
    fits_half = dbl_x <= par_x;
    fits_full = len_x <= par_x;
    slots_ok  = idle_x >= dbl_x;
    if (len_x == '0)             mode = BK_NONE;
    else if (fits_half && slots_ok) mode = BK_MIRROR;
    else if (fits_full)          mode = BK_COPY;
    else                         mode = BK_PARITY;
  end
endmodule

// File: rtl/lsbsel_mask.sv
module lsbsel_mask #(
  parameter int MAX_PAGES = 8,
  parameter int LEN_W     = 4,
  parameter int PAIR_GAP  = 3
) (
  input  logic [LEN_W-1:0]     len,
  input  logic [MAX_PAGES-1:0] ext,
  output logic [MAX_PAGES-1:0] need
);
  localparam int CW = LEN_W + $clog2(MAX_PAGES + PAIR_GAP + 1) + 1;

  logic [CW-1:0] len_x;
  assign len_x = CW'(len);

  for (genvar i = 0; i < MAX_PAGES; i++) begin : g_pos
    localparam logic [CW-1:0] POS  = CW'(i);
    localparam logic [CW-1:0] REACH = CW'(i + PAIR_GAP);
    assign need[i] = ext[i] && (POS < len_x) && (REACH >= len_x);
  end
endmodule

// File: rtl/lsbsel_count.sv
module lsbsel_count #(
  parameter int MAX_PAGES = 8,
  parameter int CNT_W     = 4
) (
  input  logic [MAX_PAGES-1:0] need,
  input  logic                 halve,
  output logic [CNT_W-1:0]     count
);
  logic [CNT_W:0] sum;
  logic [CNT_W:0] half;

  always_comb begin
    sum = '0;
    for (int k = 0; k < MAX_PAGES; k++) sum = sum + (CNT_W+1)'(need[k]);
    half  = (sum + (CNT_W+1)'(1)) >> 1;
    count = halve ? half[CNT_W-1:0] : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/lsb_backup_selector.sv
module lsb_backup_selector
  import lsbsel_pkg::*;
#(
  parameter int MAX_PAGES = 8,
  parameter int PAR_W     = 4,
  parameter int SLOT_W    = 5,
  parameter int PAIR_GAP  = 3,
  localparam int LEN_W    = $clog2(MAX_PAGES + 1),
  localparam int CNT_W    = $clog2(MAX_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [PAR_W-1:0]     par_pages,
  input  logic [SLOT_W-1:0]    idle_slots,
  input  logic [MAX_PAGES-1:0] lsb_ext,
  output logic                 dec_valid,
  output logic [1:0]           dec_mode,
  output logic [MAX_PAGES-1:0] bkp_flags,
  output logic [CNT_W-1:0]     bkp_count
);
  bk_mode_e              nx_mode;
  logic [MAX_PAGES-1:0]  nx_need;
  logic [CNT_W-1:0]      nx_count;

  lsbsel_mode #(.LEN_W(LEN_W), .PAR_W(PAR_W), .SLOT_W(SLOT_W)) u_mode (
    .len (req_len),
    .par (par_pages),
    .idle(idle_slots),
    .mode(nx_mode)
  );

  lsbsel_mask #(.MAX_PAGES(MAX_PAGES), .LEN_W(LEN_W), .PAIR_GAP(PAIR_GAP)) u_mask (
    .len (req_len),
    .ext (lsb_ext),
    .need(nx_need)
  );

  lsbsel_count #(.MAX_PAGES(MAX_PAGES), .CNT_W(CNT_W)) u_count (
    .need (nx_need),
    .halve(nx_mode == BK_PARITY),
    .count(nx_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_mode  <= BK_NONE;
      bkp_flags <= '0;
      bkp_count <= '0;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) begin
        dec_mode  <= nx_mode;
        bkp_flags <= nx_need;
        bkp_count <= nx_count;
      end
    end
  end
endmodule

// File: rtl/lsbsel_checker.sv
module lsbsel_checker #(
  parameter int MAX_PAGES = 8,
  parameter int PAR_W     = 4,
  parameter int SLOT_W    = 5,
  parameter int PAIR_GAP  = 3,
  parameter int LEN_W     = 4,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [LEN_W-1:0]     req_len,
  input logic [PAR_W-1:0]     par_pages,
  input logic [SLOT_W-1:0]    idle_slots,
  input logic                 dec_valid,
  input logic [1:0]           dec_mode,
  input logic [MAX_PAGES-1:0] bkp_flags,
  input logic [CNT_W-1:0]     bkp_count
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);
  a_r3_zero_len: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_len == '0) |=> (dec_mode == 2'd0 && bkp_flags == '0 && bkp_count == '0));
  a_r5_no_slots: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_len != '0 && int'(req_len) <= int'(par_pages)
     && int'(idle_slots) < 2*int'(req_len)) |=> dec_mode == 2'd2);
  a_r6_parity: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_len) > int'(par_pages)) |=> dec_mode == 2'd3);
  a_r7_tail_only: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $countones(bkp_flags) <= PAIR_GAP);
  a_r8_count_plain: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_mode != 2'd3) |-> int'(bkp_count) == $countones(bkp_flags));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(dec_mode) && $stable(bkp_flags) && $stable(bkp_count)));
endmodule

bind lsb_backup_selector lsbsel_checker #(
  .MAX_PAGES(MAX_PAGES), .PAR_W(PAR_W), .SLOT_W(SLOT_W),
  .PAIR_GAP(PAIR_GAP), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
  .par_pages(par_pages), .idle_slots(idle_slots), .dec_valid(dec_valid),
  .dec_mode(dec_mode), .bkp_flags(bkp_flags), .bkp_count(bkp_count)
);

// File: tb/lsb_backup_selector_bench.sv
`timescale 1ns/1ps
module lsb_backup_selector_bench;
  localparam int MAX_PAGES = 8;
  localparam int PAR_W     = 4;
  localparam int SLOT_W    = 5;
  localparam int PAIR_GAP  = 3;
  localparam int LEN_W     = $clog2(MAX_PAGES + 1);
  localparam int CNT_W     = $clog2(MAX_PAGES + 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 req_valid = 1'b0;
  logic [LEN_W-1:0]     req_len = '0;
  logic [PAR_W-1:0]     par_pages = '0;
  logic [SLOT_W-1:0]    idle_slots = '0;
  logic [MAX_PAGES-1:0] lsb_ext = '0;
  logic                 dec_valid;
  logic [1:0]           dec_mode;
  logic [MAX_PAGES-1:0] bkp_flags;
  logic [CNT_W-1:0]     bkp_count;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lsb_backup_selector #(.MAX_PAGES(MAX_PAGES), .PAR_W(PAR_W), .SLOT_W(SLOT_W),
                        .PAIR_GAP(PAIR_GAP)) u_lsb_backup_selector (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .par_pages(par_pages), .idle_slots(idle_slots), .lsb_ext(lsb_ext),
    .dec_valid(dec_valid), .dec_mode(dec_mode), .bkp_flags(bkp_flags),
    .bkp_count(bkp_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_mode(int len, int par, int idle);
    if (len == 0) return 0;
    if (2*len <= par && idle >= 2*len) return 1;
    if (len <= par) return 2;
    return 3;
  endfunction

  task automatic run_req(input int len, input int par, input int idle, input int ext);
    int em, ecnt, n;
    int ef;
    string tag;
    @(negedge clk);
    req_len    = LEN_W'(len);
    par_pages  = PAR_W'(par);
    idle_slots = SLOT_W'(idle);
    lsb_ext    = MAX_PAGES'(ext);
    req_valid  = 1'b1;
    em = ref_mode(len, par, idle);
    ef = 0;
    n  = 0;
    for (int i = 0; i < MAX_PAGES; i++)
      if (i < len && i + PAIR_GAP >= len && ext[i]) begin
        ef = ef | (1 << i);
        n++;
      end
    ecnt = (em == 3) ? (n + 1) / 2 : n;
    tag = (em == 0) ? "R3" : (em == 1) ? "R4" : (em == 2) ? "R5" : "R6";
    @(negedge clk);
    check(dec_valid == 1'b1, "R2 valid after strobe", int'(dec_valid), 1);
    check(int'(dec_mode) == em, tag, int'(dec_mode), em);
    check(int'(bkp_flags) == ef, "R7 flags", int'(bkp_flags), ef);
    check(int'(bkp_count) == ecnt, "R8 count", int'(bkp_count), ecnt);
    req_valid = 1'b0;
    req_len   = ~req_len;
    lsb_ext   = ~lsb_ext;
    par_pages = ~par_pages;
    @(negedge clk);
    check(dec_valid == 1'b0, "R2 valid low", int'(dec_valid), 0);
    check(int'(dec_mode) == em && int'(bkp_flags) == ef && int'(bkp_count) == ecnt,
          "R9 hold", int'(bkp_flags), ef);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dec_valid == 1'b0 && dec_mode == 2'd0 && bkp_flags == '0 && bkp_count == '0,
          "R1 reset", int'(bkp_flags), 0);
    rst = 1'b0;
    @(negedge clk);
    check(dec_valid == 1'b0 && dec_mode == 2'd0 && bkp_count == '0,
          "R1 after reset", int'(dec_mode), 0);
    for (int len = 0; len <= MAX_PAGES; len++)
      for (int par = 0; par < (1 << PAR_W); par++)
        for (int iv = 0; iv < 4; iv++)
          for (int ev = 0; ev < 4; ev++) begin
            int idle, ext;
            idle = (iv == 0) ? 0 : (iv == 1) ? 2*len - 1 : (iv == 2) ? 2*len : 31;
            if (idle < 0) idle = 0;
            if (idle > 31) idle = 31;
            ext = (ev == 0) ? 8'hFF : (ev == 1) ? 8'hA5 : (ev == 2) ? 8'h5A
                : ((len * 37 + par * 11 + iv * 5) & 8'hFF);
            run_req(len, par, idle, ext);
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule